// File: doc/BRIEF.md
# Serial Character Receiver with Error Flags

This block receives asynchronous serial characters on a single line. A separate oversampling tick runs at sixteen times the bit rate. A falling edge on the idle line starts a candidate frame. The candidate is confirmed only if the line is still low at the middle of the start bit. The block then samples seven or eight data bits at their centres, in either LSB-first or MSB-first order. An optional parity bit and one stop bit follow the data.

When a frame ends, the assembled character moves into a holding register and a full flag is raised. A level interrupt stays asserted while the interrupt enable and the full flag are both set. A read strobe from the CPU side empties the holding register.

Parity, overrun and framing problems each set their own sticky flag, and only an explicit clear pulse removes them. The holding register counts as valid only while it is full and all three flags are low.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset, data_o is 0, and full_o, perr_o, oerr_o, ferr_o, irq_o and valid_o are all 0.
- R2: While rx_en_i is 0, the receiver stays idle and no frame completes, whatever the line does.
- R3: A start bit is accepted only if the synchronised line is still low at the centre of the start bit (half a bit period after the falling edge is seen). A shorter low pulse is discarded and produces no frame.
- R4: In 8-bit mode with msb_first_i = 0, the first data bit after the start bit lands in data_o[0]. With msb_first_i = 1, the first data bit lands in data_o[7].
- R5: In 7-bit mode (char7_i = 1), the seven data bits fill data_o[6:0] in the selected order (the first bit goes to data_o[0] when LSB-first and to data_o[6] when MSB-first). data_o[7] reads 0.
- R6: When a frame completes while the holding register is empty, the character is loaded into data_o and full_o becomes 1.
- R7: With par_en_i = 1, one parity bit follows the data bits. With par_odd_i = 0, the data bits plus the parity bit must contain an even number of ones; with par_odd_i = 1, an odd number. A mismatch sets perr_o.
- R8: A stop bit sampled as 0 sets ferr_o.
- R9: A frame that completes while full_o is 1 (and no read happens in the same cycle) sets oerr_o and leaves data_o unchanged.
- R10: A one-cycle pulse on rd_i clears full_o.
- R11: perr_o, oerr_o and ferr_o stay set through reads. They are cleared only by a pulse on err_clr_i. A new error in the same cycle as the clear wins.
- R12: irq_o is 1 exactly when irq_en_i is 1 and full_o is 1.
- R13: valid_o is 1 only when full_o is 1 and perr_o, oerr_o and ferr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling tick, OVS ticks per bit |
| rx_en_i | input | 1 | Receiver enable |
| char7_i | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| msb_first_i | input | 1 | 1 selects MSB-first bit order |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Data register read strobe |
| err_clr_i | input | 1 | Clear all three error flags |
| data_o | output | 8 | Received character |
| full_o | output | 1 | Holding register full |
| perr_o | output | 1 | Parity error flag |
| oerr_o | output | 1 | Overrun error flag |
| ferr_o | output | 1 | Framing error flag |
| irq_o | output | 1 | Receive interrupt level |
| valid_o | output | 1 | Full and error-free |

## Verification
The bench uses OVS = 16 and two synchroniser stages, and holds tick_i high every clock, so one bit lasts sixteen cycles. These short frames leave room to cover every combination of bit order, character length and parity sense, plus back-to-back frames for overrun. With only two synchroniser stages, the bench can place a low stop bit, and a short low glitch, precisely against the half-bit confirmation point. This lets it show that a truncated low level after a framing error is rejected as a false start.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_frame_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= 1'b1;
        else         pipe_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rx_en_i,
  input  logic      tick_i,
  input  logic      rx_s_i,
  input  logic      char7_i,
  input  logic      msb_first_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        idx_q;
  logic [CHAR_W-1:0] sh_q;
  logic              par_q;
  logic [2:0]        last_idx;
  logic [2:0]        pos;
  logic              at_half, at_end;

  assign last_idx = char7_i ? 3'd6 : 3'd7;
  assign pos      = msb_first_i ? (last_idx - idx_q) : idx_q;
  assign at_half  = (cnt_q == HALF);
  assign at_end   = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      done_o  <= 1'b0;
      frame_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!rx_en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rx_s_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
          end
          ST_START: begin
            if (at_half) begin
              cnt_q   <= '0;
              state_q <= rx_s_i ? ST_IDLE : ST_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (at_end) begin
              cnt_q     <= '0;
              sh_q[pos] <= rx_s_i;
              idx_q     <= idx_q + 1'b1;
              if (idx_q == last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PAR: begin
            if (at_end) begin
              cnt_q   <= '0;
              par_q   <= rx_s_i;
              state_q <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (at_end) begin
              cnt_q         <= '0;
              state_q       <= ST_IDLE;
              done_o        <= 1'b1;
              frame_o.data  <= sh_q;
              frame_o.perr  <= par_en_i & ((^sh_q ^ par_q) != par_odd_i);
              frame_o.ferr  <= ~rx_s_i;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_disabled_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (state_q == ST_IDLE) && !done_o);

  p_glitch_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) && rx_en_i && tick_i && at_half && rx_s_i |=> (state_q == ST_IDLE));

  p_done_after_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(state_q) == ST_STOP) && (frame_o.ferr == !$past(rx_s_i)));
endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_frame_t         frame_i,
  input  logic              char7_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              oerr_o,
  output logic              ferr_o
);
  logic keep, load, ovr;

  // read in the same cycle frees the register before the new frame lands
  assign keep = full_o & ~rd_i;
  assign load = done_i & ~keep;
  assign ovr  = done_i & keep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      perr_o <= 1'b0;
      oerr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      full_o <= done_i | keep;
      if (load) data_o <= frame_i.data;
      perr_o <= (perr_o & ~err_clr_i) | (load & frame_i.perr);
      ferr_o <= (ferr_o & ~err_clr_i) | (load & frame_i.ferr);
      oerr_o <= (oerr_o & ~err_clr_i) | ovr;
    end
  end

  p_load_sets_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> full_o);

  p_overrun_keeps_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && full_o && !rd_i |=> oerr_o && $stable(data_o));

  p_read_clears_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> !full_o);

  p_oerr_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oerr_o && !err_clr_i |=> oerr_o);

  p_perr_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o && !err_clr_i |=> perr_o);

  p_char7_msb_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !keep && char7_i |=> !data_o[CHAR_W-1]);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic       rx_en_i,
  input  logic       char7_i,
  input  logic       msb_first_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       irq_en_i,
  input  logic       rd_i,
  input  logic       err_clr_i,
  output logic [7:0] data_o,
  output logic       full_o,
  output logic       perr_o,
  output logic       oerr_o,
  output logic       ferr_o,
  output logic       irq_o,
  output logic       valid_o
);
  logic      rx_s;
  logic      done;
  rx_frame_t frame;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_framer #(.OVS(OVS)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_en_i    (rx_en_i),
    .tick_i     (tick_i),
    .rx_s_i     (rx_s),
    .char7_i    (char7_i),
    .msb_first_i(msb_first_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .done_o     (done),
    .frame_o    (frame)
  );

  uart_rx_holding u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .frame_i  (frame),
    .char7_i  (char7_i),
    .rd_i     (rd_i),
    .err_clr_i(err_clr_i),
    .data_o   (data_o),
    .full_o   (full_o),
    .perr_o   (perr_o),
    .oerr_o   (oerr_o),
    .ferr_o   (ferr_o)
  );

  assign irq_o   = irq_en_i & full_o;
  assign valid_o = full_o & ~(perr_o | oerr_o | ferr_o);

  p_irq_on_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) && irq_en_i |-> irq_o);

  p_valid_needs_clean_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oerr_o) |-> !valid_o);
endmodule

// File: tb/uart_rx_flags_test.sv
module uart_rx_flags_test;
  localparam int OVS = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx = 1'b1, tick = 1'b1, rx_en = 1'b1;
  logic c7 = 1'b0, msb = 1'b0, pen = 1'b0, podd = 1'b0;
  logic irq_en = 1'b1, rd = 1'b0, clr = 1'b0;
  logic [7:0] data;
  logic full, perr, oerr, ferr, irq, valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_rx_flags #(.OVS(OVS), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .tick_i(tick), .rx_en_i(rx_en),
    .char7_i(c7), .msb_first_i(msb), .par_en_i(pen), .par_odd_i(podd),
    .irq_en_i(irq_en), .rd_i(rd), .err_clr_i(clr), .data_o(data),
    .full_o(full), .perr_o(perr), .oerr_o(oerr), .ferr_o(ferr),
    .irq_o(irq), .valid_o(valid)
  );

  typedef struct packed {
    logic       c7, msb, pen, podd, badp, badstop;
    logic [7:0] pay, exp;
    logic       pe, fe;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h7F, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h81, 8'h01, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h5A, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3, 8'hC3, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic b, input int n);
    rx = b;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic pay_c7, input logic pay_msb, input logic p_en,
                      input logic p_odd, input logic [7:0] pay,
                      input logic badp, input logic badstop);
    int n;
    logic pb;
    c7 = pay_c7; msb = pay_msb; pen = p_en; podd = p_odd;
    n  = pay_c7 ? 7 : 8;
    pb = (pay_c7 ? ^pay[6:0] : ^pay) ^ p_odd ^ badp;
    drive(1'b0, OVS);
    for (int i = 0; i < n; i++) drive(pay[pay_msb ? n-1-i : i], OVS);
    if (p_en) drive(pb, OVS);
    if (badstop) begin
      drive(1'b0, 12);
      drive(1'b1, 20);
    end else drive(1'b1, OVS);
    drive(1'b1, 24);
  endtask

  task automatic pulse_rd();
    rd = 1'b1; @(posedge clk); #1; rd = 1'b0; @(posedge clk); #1;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(posedge clk); #1; clr = 1'b0; @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 data", data, 0);
    chk("R1 flags", {full, perr, oerr, ferr, irq, valid}, 0);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    foreach (VECS[k]) begin
      send(VECS[k].c7, VECS[k].msb, VECS[k].pen, VECS[k].podd, VECS[k].pay,
           VECS[k].badp, VECS[k].badstop);
      chk("R4 R5 data order", data, VECS[k].exp);
      chk("R6 full", full, 1);
      chk("R7 parity", perr, VECS[k].pe);
      chk("R8 framing", ferr, VECS[k].fe);
      chk("R12 irq", irq, 1);
      chk("R13 valid", valid, !(VECS[k].pe || VECS[k].fe));
      pulse_rd();
      chk("R10 read clears full", full, 0);
      chk("R11 sticky through read", {perr, ferr}, {VECS[k].pe, VECS[k].fe});
      pulse_clr();
      chk("R11 clear", {perr, oerr, ferr}, 0);
    end

    // R2 disabled receiver ignores a frame
    rx_en = 1'b0;
    send(1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0);
    chk("R2 disabled", {full, ferr, perr}, 0);
    rx_en = 1'b1;
    drive(1'b1, 8);

    // R3 short low glitch rejected, then a real frame still received
    drive(1'b0, 5);
    drive(1'b1, 60);
    chk("R3 glitch rejected", full, 0);
    send(1'b0, 1'b0, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0);
    chk("R3 frame after glitch", data, 8'h96);

    // R9 overrun keeps first data
    send(1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0);
    chk("R9 oerr", oerr, 1);
    chk("R9 data kept", data, 8'h96);
    chk("R13 valid low on overrun", valid, 0);
    pulse_rd();
    chk("R11 oerr sticky", oerr, 1);
    pulse_clr();
    chk("R11 oerr clear", oerr, 0);

    // R12 interrupt masked
    irq_en = 1'b0;
    send(1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, 1'b0, 1'b0);
    chk("R12 masked irq", {full, irq}, 2'b10);
    chk("R4 msb first", data, 8'h0F);
    irq_en = 1'b1;
    #1;
    chk("R12 irq enabled", irq, 1);
    pulse_rd();
    chk("R12 irq drops", irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule